// File: doc/BRIEF.md
# PCI Target Configuration Space and Window Decoder

This block is the configuration side of a PCI 2.2 target. During an address phase it checks whether the cycle is a Type 0 configuration access aimed at this device. That is the case when the device-select line is high and the low two address bits are zero. It then remembers which configuration dword was named. In the following data phase it either presents that dword on `rd_data` or updates it under control of the active-low byte enables.

The block holds one memory window and one I/O window. Each has a base register whose size is fixed at build time by a parameter. Software finds the size the usual way: it writes all ones and reads the value back. On every address phase the incoming address is compared against both windows. The result is reported to the transaction engine as separate one-cycle memory-hit and I/O-hit strobes. Each window only answers when its enable bit in the command register is set. The status word advertises slow device-select timing.

The bus command and the byte enables share the `cbe_n` pins. During an address phase the pins carry the raw command code. During a data phase they carry the active-low byte enables.

Top module: `pci_cfg_decoder`

## Requirements
- R1: After reset the command bits are zero, dword 4 (memory window base) reads 0x00000000, dword 5 (I/O window base) reads 0x00000001, and no hit strobe is raised.
- R2: A configuration hit is taken only when all three hold at the address phase: the command is 1010 (read) or 1011 (write), idsel is 1, and ad_in[1:0] is 00. The dword index comes from ad_in[7:2]. `cfg_hit` rises in the cycle after the address phase. Otherwise no register changes on the following data phase.
- R3: Dword 0 reads {DEVICE_ID, VENDOR_ID} and dword 2 reads {CLASS_CODE, REV_ID}. Writes to them have no effect.
- R4: Dword 1 reads {status, command}. The status half is read-only with bits 10:9 equal to binary 10 (slow device select) and all other status bits zero, so the upper half reads 0x0400.
- R5: During a configuration write, byte lane n is updated only when cbe_n[n] is 0.
- R6: In the memory base (dword 4), bits below MEM_SIZE_LOG2 read zero and bit 0 reads 0. Writing all ones with the default size of 4 KiB reads back 0xFFFFF000.
- R7: In the I/O base (dword 5), bits below IO_SIZE_LOG2 read zero except bit 0, which reads 1. Writing all ones with the default size of 16 bytes reads back 0xFFFFFFF1.
- R8: `mem_hit` is 1 in the cycle after an address phase whose command is 0110, 0111, 1100, 1110 or 1111. The address must match the memory base above MEM_SIZE_LOG2, and command bit 1 (memory enable) must be set.
- R9: `io_hit` is 1 in the cycle after an address phase whose command is 0010 or 0011. The address must match the I/O base above IO_SIZE_LOG2, and command bit 0 (I/O enable) must be set.
- R10: Only command bits 1:0 are writable. Command bits 15:2 always read zero.
- R11: Each hit strobe is high for a single cycle per address phase, and at most one of the three strobes is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_phase | input | 1 | High for the one cycle of an address phase |
| ad_in | input | 32 | Address (address phase) or write data (data phase) |
| cbe_n | input | 4 | Bus command (address phase) or active-low byte enables (data phase) |
| idsel | input | 1 | Configuration device select |
| data_phase | input | 1 | High for the cycle in which a data word is transferred |
| rd_data | output | 32 | Contents of the configuration dword named in the last configuration address phase |
| cfg_hit | output | 1 | Configuration access claimed |
| mem_hit | output | 1 | Memory window claimed |
| io_hit | output | 1 | I/O window claimed |

## Verification
All three hit strobes are registered. Each is due one clock after the address-phase edge, so the bench drives every phase on a falling edge and reads the strobes on the next falling edge. It also checks that they are low again one cycle later. `rd_data` follows the dword index latched at that same edge, so a read is sampled half a cycle after the address-phase edge. A configuration write takes effect at the data-phase edge. Its result is checked only through a later configuration read, which also confirms that a write that should be ignored left the register as it was.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  localparam logic [3:0] CMD_IO_RD    = 4'b0010;
  localparam logic [3:0] CMD_IO_WR    = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD   = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR   = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD   = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR   = 4'b1011;
  localparam logic [3:0] CMD_MEM_RDM  = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL  = 4'b1110;
  localparam logic [3:0] CMD_MEM_WRI  = 4'b1111;

  localparam logic [5:0] IDX_ID     = 6'd0;
  localparam logic [5:0] IDX_CMDSTS = 6'd1;
  localparam logic [5:0] IDX_CLASS  = 6'd2;
  localparam logic [5:0] IDX_MEMBAR = 6'd4;
  localparam logic [5:0] IDX_IOBAR  = 6'd5;

  localparam logic [15:0] STATUS_VALUE = 16'h0400;

  typedef enum logic [1:0] {SP_NONE, SP_MEM, SP_IO, SP_CFG} space_e;

  function automatic logic [31:0] size_mask(input int unsigned log2);
    return 32'hFFFF_FFFF << log2;
  endfunction

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  be_n);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = be_n[b] ? old_w[b*8 +: 8] : new_w[b*8 +: 8];
    return r;
  endfunction

  function automatic logic window_hit(input logic [31:0] addr,
                                      input logic [31:0] base,
                                      input logic [31:0] mask);
    return ((addr ^ base) & mask) == 32'h0;
  endfunction

  function automatic space_e classify(input logic [3:0] cmd);
    case (cmd)
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM, CMD_MEM_RDL, CMD_MEM_WRI: return SP_MEM;
      CMD_IO_RD, CMD_IO_WR:                                          return SP_IO;
      CMD_CFG_RD, CMD_CFG_WR:                                        return SP_CFG;
      default:                                                       return SP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pci_cfg_addr_dec.sv
module pci_cfg_addr_dec
  import pci_cfg_pkg::*;
#(
  parameter int unsigned MEM_SIZE_LOG2 = 12,
  parameter int unsigned IO_SIZE_LOG2  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_phase,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  input  logic        idsel,
  input  logic        data_phase,
  input  logic        mem_en,
  input  logic        io_en,
  input  logic [31:0] mem_base,
  input  logic [31:0] io_base,
  output logic        cfg_hit,
  output logic        mem_hit,
  output logic        io_hit,
  output logic [5:0]  cfg_idx,
  output logic        cfg_wr_fire
);

  localparam logic [31:0] MEM_MASK = size_mask(MEM_SIZE_LOG2);
  localparam logic [31:0] IO_MASK  = size_mask(IO_SIZE_LOG2);

  space_e space;
  logic   cfg_take, mem_take, io_take;
  logic   wr_pend;

  always_comb begin
    space    = classify(cbe_n);
    cfg_take = addr_phase && space == SP_CFG && idsel && ad_in[1:0] == 2'b00;
    mem_take = addr_phase && space == SP_MEM && mem_en && window_hit(ad_in, mem_base, MEM_MASK);
    io_take  = addr_phase && space == SP_IO && io_en && window_hit(ad_in, io_base, IO_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_hit <= 1'b0;
      mem_hit <= 1'b0;
      io_hit  <= 1'b0;
      cfg_idx <= '0;
      wr_pend <= 1'b0;
    end else begin
      cfg_hit <= cfg_take;
      mem_hit <= mem_take;
      io_hit  <= io_take;
      if (cfg_take) cfg_idx <= ad_in[7:2];
      if (addr_phase)      wr_pend <= cfg_take && cbe_n == CMD_CFG_WR;
      else if (data_phase) wr_pend <= 1'b0;
    end
  end

  assign cfg_wr_fire = wr_pend && data_phase;

endmodule

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1234,
  parameter logic [15:0] DEVICE_ID     = 16'hFACE,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [7:0]  REV_ID        = 8'h01,
  parameter int unsigned MEM_SIZE_LOG2 = 12,
  parameter int unsigned IO_SIZE_LOG2  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fire,
  input  logic [5:0]  idx,
  input  logic [31:0] wdata,
  input  logic [3:0]  be_n,
  output logic [31:0] rd_data,
  output logic        mem_en,
  output logic        io_en,
  output logic [31:0] mem_base,
  output logic [31:0] io_base
);

  localparam logic [31:0] MEM_MASK = size_mask(MEM_SIZE_LOG2);
  localparam logic [31:0] IO_MASK  = size_mask(IO_SIZE_LOG2);

  logic [1:0]  cmd_bits;
  logic [31:0] cur_word, next_word;

  always_comb begin
    case (idx)
      IDX_ID:     cur_word = {DEVICE_ID, VENDOR_ID};
      IDX_CMDSTS: cur_word = {STATUS_VALUE, 14'h0, cmd_bits};
      IDX_CLASS:  cur_word = {CLASS_CODE, REV_ID};
      IDX_MEMBAR: cur_word = mem_base;
      IDX_IOBAR:  cur_word = io_base | 32'h1;
      default:    cur_word = 32'h0;
    endcase
    next_word = merge_bytes(cur_word, wdata, be_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_bits <= 2'b00;
      mem_base <= 32'h0;
      io_base  <= 32'h0;
    end else if (wr_fire) begin
      case (idx)
        IDX_CMDSTS: cmd_bits <= next_word[1:0];
        IDX_MEMBAR: mem_base <= next_word & MEM_MASK;
        IDX_IOBAR:  io_base  <= next_word & IO_MASK;
        default: ;
      endcase
    end
  end

  assign rd_data = cur_word;
  assign io_en   = cmd_bits[0];
  assign mem_en  = cmd_bits[1];

endmodule

// File: rtl/pci_cfg_decoder.sv
module pci_cfg_decoder #(
  parameter logic [15:0] VENDOR_ID     = 16'h1234,
  parameter logic [15:0] DEVICE_ID     = 16'hFACE,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [7:0]  REV_ID        = 8'h01,
  parameter int unsigned MEM_SIZE_LOG2 = 12,
  parameter int unsigned IO_SIZE_LOG2  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_phase,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  input  logic        idsel,
  input  logic        data_phase,
  output logic [31:0] rd_data,
  output logic        cfg_hit,
  output logic        mem_hit,
  output logic        io_hit
);

  logic        mem_en, io_en, cfg_wr_fire;
  logic [31:0] mem_base, io_base;
  logic [5:0]  cfg_idx;

  pci_cfg_addr_dec #(
    .MEM_SIZE_LOG2(MEM_SIZE_LOG2),
    .IO_SIZE_LOG2 (IO_SIZE_LOG2)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_phase (addr_phase),
    .ad_in      (ad_in),
    .cbe_n      (cbe_n),
    .idsel      (idsel),
    .data_phase (data_phase),
    .mem_en     (mem_en),
    .io_en      (io_en),
    .mem_base   (mem_base),
    .io_base    (io_base),
    .cfg_hit    (cfg_hit),
    .mem_hit    (mem_hit),
    .io_hit     (io_hit),
    .cfg_idx    (cfg_idx),
    .cfg_wr_fire(cfg_wr_fire)
  );

  pci_cfg_regs #(
    .VENDOR_ID    (VENDOR_ID),
    .DEVICE_ID    (DEVICE_ID),
    .CLASS_CODE   (CLASS_CODE),
    .REV_ID       (REV_ID),
    .MEM_SIZE_LOG2(MEM_SIZE_LOG2),
    .IO_SIZE_LOG2 (IO_SIZE_LOG2)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (cfg_wr_fire),
    .idx     (cfg_idx),
    .wdata   (ad_in),
    .be_n    (cbe_n),
    .rd_data (rd_data),
    .mem_en  (mem_en),
    .io_en   (io_en),
    .mem_base(mem_base),
    .io_base (io_base)
  );

endmodule

// File: rtl/pci_cfg_decoder_chk.sv
module pci_cfg_decoder_chk #(
  parameter int unsigned MEM_SIZE_LOG2 = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_phase,
  input logic        cfg_hit,
  input logic        mem_hit,
  input logic        io_hit,
  input logic        mem_en,
  input logic        io_en,
  input logic [5:0]  cfg_idx,
  input logic [31:0] rd_data
);

  a_r11_hits_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_hit, mem_hit, io_hit}));

  a_r11_hit_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hit || mem_hit || io_hit) |-> $past(addr_phase));

  a_r8_mem_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> $past(mem_en));

  a_r9_io_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> $past(io_en));

  a_r10_cmd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == 6'd1) |-> (rd_data[15:2] == 14'h0 && rd_data[26:25] == 2'b10));

  a_r6_mem_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == 6'd4) |-> (rd_data[MEM_SIZE_LOG2-1:0] == '0));

  a_r7_io_bit0_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == 6'd5) |-> rd_data[0]);

endmodule

bind pci_cfg_decoder pci_cfg_decoder_chk #(.MEM_SIZE_LOG2(MEM_SIZE_LOG2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_phase(addr_phase),
  .cfg_hit   (cfg_hit),
  .mem_hit   (mem_hit),
  .io_hit    (io_hit),
  .mem_en    (mem_en),
  .io_en     (io_en),
  .cfg_idx   (cfg_idx),
  .rd_data   (rd_data)
);

// File: tb/pci_cfg_decoder_test.sv
module pci_cfg_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_phase = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        idsel = 1'b0;
  logic        data_phase = 1'b0;
  logic [31:0] rd_data;
  logic        cfg_hit, mem_hit, io_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .ad_in(ad_in),
    .cbe_n(cbe_n), .idsel(idsel), .data_phase(data_phase),
    .rd_data(rd_data), .cfg_hit(cfg_hit), .mem_hit(mem_hit), .io_hit(io_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive an address phase; returns with the registered results visible
  task automatic addr_cycle(input logic [3:0] cmd, input logic [31:0] a, input logic sel);
    @(negedge clk);
    addr_phase = 1'b1; cbe_n = cmd; ad_in = a; idsel = sel;
    @(negedge clk);
    addr_phase = 1'b0; idsel = 1'b0; cbe_n = 4'hF; ad_in = '0;
  endtask

  task automatic data_cycle(input logic [31:0] d, input logic [3:0] be);
    data_phase = 1'b1; cbe_n = be; ad_in = d;
    @(negedge clk);
    data_phase = 1'b0; cbe_n = 4'hF; ad_in = '0;
  endtask

  task automatic cfg_rd(input int idx, output logic [31:0] v);
    addr_cycle(4'b1010, 32'(idx) << 2, 1'b1);
    v = rd_data;
    data_cycle(32'h0, 4'h0);
  endtask

  task automatic cfg_wr(input int idx, input logic [31:0] d, input logic [3:0] be);
    addr_cycle(4'b1011, 32'(idx) << 2, 1'b1);
    data_cycle(d, be);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 no hits after reset", {29'h0, cfg_hit, mem_hit, io_hit}, 32'h0);
    addr_cycle(4'b0110, 32'h0, 1'b0);
    check("R1/R8 mem disabled at reset", {31'h0, mem_hit}, 32'h0);
    cfg_rd(1, v); check("R1/R4 cmd/status at reset", v, 32'h0400_0000);
    cfg_rd(4, v); check("R1 mem base reset", v, 32'h0);
    cfg_rd(5, v); check("R1 io base reset", v, 32'h1);
  endtask

  task automatic t_ids;
    logic [31:0] v;
    cfg_wr(0, 32'hFFFF_FFFF, 4'h0);
    cfg_rd(0, v); check("R3 id dword", v, 32'hFACE_1234);
    cfg_wr(2, 32'h0, 4'h0);
    cfg_rd(2, v); check("R3 class dword", v, 32'h0200_0001);
  endtask

  task automatic t_cfg_gate;
    logic [31:0] v;
    addr_cycle(4'b1011, 32'h4, 1'b0);
    check("R2 no cfg_hit without idsel", {31'h0, cfg_hit}, 32'h0);
    data_cycle(32'hFFFF_FFFF, 4'h0);
    addr_cycle(4'b1011, 32'h5, 1'b1);
    check("R2 no cfg_hit for type 1", {31'h0, cfg_hit}, 32'h0);
    data_cycle(32'hFFFF_FFFF, 4'h0);
    addr_cycle(4'b1010, 32'h4, 1'b1);
    check("R2 cfg_hit on type 0", {31'h0, cfg_hit}, 32'h1);
    v = rd_data;
    @(negedge clk);
    check("R11 cfg_hit one cycle", {31'h0, cfg_hit}, 32'h0);
    data_cycle(32'h0, 4'h0);
    check("R2 ignored writes left cmd", v, 32'h0400_0000);
  endtask

  task automatic t_sizing;
    logic [31:0] v;
    cfg_wr(4, 32'hFFFF_FFFF, 4'h0);
    cfg_rd(4, v); check("R6 mem sizing", v, 32'hFFFF_F000);
    cfg_wr(5, 32'hFFFF_FFFF, 4'h0);
    cfg_rd(5, v); check("R7 io sizing", v, 32'hFFFF_FFF1);
    cfg_wr(4, 32'h1234_5678, 4'b0111);
    cfg_rd(4, v); check("R5 byte lane 3 only", v, 32'h12FF_F000);
    cfg_wr(4, 32'h4000_0000, 4'h0);
    cfg_rd(4, v); check("R5 all lanes", v, 32'h4000_0000);
    cfg_wr(5, 32'h0000_C000, 4'h0);
    cfg_rd(5, v); check("R7 io base set", v, 32'h0000_C001);
    cfg_wr(1, 32'hFFFF_FFFF, 4'h0);
    cfg_rd(1, v); check("R10/R4 cmd write mask", v, 32'h0400_0003);
  endtask

  task automatic t_hits;
    addr_cycle(4'b0110, 32'h4000_0ABC, 1'b0);
    check("R8 mem read hit", {29'h0, cfg_hit, mem_hit, io_hit}, 32'h2);
    @(negedge clk);
    check("R11 mem_hit one cycle", {31'h0, mem_hit}, 32'h0);
    addr_cycle(4'b1111, 32'h4000_0000, 1'b0);
    check("R8 mem write-invalidate hit", {31'h0, mem_hit}, 32'h1);
    addr_cycle(4'b0111, 32'h4000_1000, 1'b0);
    check("R8 mem miss above window", {31'h0, mem_hit}, 32'h0);
    addr_cycle(4'b0010, 32'h4000_0000, 1'b0);
    check("R8/R9 io cmd at mem addr", {29'h0, cfg_hit, mem_hit, io_hit}, 32'h0);
    addr_cycle(4'b0010, 32'h0000_C00F, 1'b0);
    check("R9 io hit top of window", {29'h0, cfg_hit, mem_hit, io_hit}, 32'h1);
    addr_cycle(4'b0011, 32'h0000_C010, 1'b0);
    check("R9 io miss past window", {31'h0, io_hit}, 32'h0);
  endtask

  task automatic t_enables;
    cfg_wr(1, 32'h1, 4'h0);
    addr_cycle(4'b0110, 32'h4000_0010, 1'b0);
    check("R8 mem gated off", {31'h0, mem_hit}, 32'h0);
    addr_cycle(4'b0011, 32'h0000_C004, 1'b0);
    check("R9 io enabled alone", {31'h0, io_hit}, 32'h1);
    cfg_wr(1, 32'h2, 4'b1110);
    addr_cycle(4'b0011, 32'h0000_C004, 1'b0);
    check("R9 io gated off", {31'h0, io_hit}, 32'h0);
    addr_cycle(4'b1100, 32'h4000_0FFC, 1'b0);
    check("R8 mem read multiple hit", {31'h0, mem_hit}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_cfg_gate();
    t_sizing();
    t_hits();
    t_enables();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule